// File: doc/BRIEF.md
# DMA Transfer Sequencer with Posted Write Buffer

This block runs one DMA channel. An active-low, level-sensitive request input starts the transfer units. Each unit reads one word from the internal bus and then writes it to the external bus. Software loads a 16-bit unit count together with source and destination start addresses, then sets the channel enable. Each unit increments both addresses by one.

A request is latched only while the channel is enabled, idle and has nothing pending. Latching closes while a unit is in progress. It reopens once the unit has handed off its write, and the level is then sampled again. This repeats until the count reaches zero. At that point the channel disables itself and pulses a done flag.

An optional one-entry posted write buffer lets an external write finish in the background while the next internal read runs. With the buffer selected, the last write is followed by one dead cycle, which counts as internal. An active-low end strobe marks the final cycle of the transfer. It is always driven when that cycle is an external write. It is withheld when the final cycle is the internal dead cycle and a posted external write is still running.

Top module: `dma_wbuf_seq`

## Requirements
- R1: When `req_n` is low at a rising edge while the channel is enabled, idle and has no pending request, a pending request is latched. `int_req` is then high from the following rising edge.
- R2: While a unit is in progress, a low pulse on `req_n` is not latched. A pulse that ends before the unit completes starts no extra unit.
- R3: With `req_n` held low, units run back to back until the count is used up. Write k goes to destination base + k and carries the data read from source base + k.
- R4: When the count reaches zero, `ch_en` clears and `done` is high for exactly one cycle. After that, a low `req_n` starts no reads.
- R5: Setting the enable while the loaded count is zero leaves `ch_en` low, and no transfer starts.
- R6: With the buffer mode off, `int_req` and `ext_req` are never high in the same cycle. Each external write completes before the next read begins.
- R7: With the buffer mode on, an external write that has not yet been acknowledged overlaps the next internal read.
- R8: The buffer holds one write. `ext_req`, `ext_addr` and `ext_wdata` hold steady until `ext_ack`. A further write stalls, so no write is lost or reordered.
- R9: With the buffer mode on, the last write is followed by exactly one dead cycle with neither bus request. `done` rises in the cycle after that dead cycle.
- R10: With the buffer mode off, `tend_n` is low in exactly the cycles in which the last write is on the external bus.
- R11: With the buffer mode on, `tend_n` is low in the dead cycle only if no posted external write is running then. Otherwise it stays high for the whole transfer.
- R12: Each unit makes one internal read. The read address holds steady until `int_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_n | input | 1 | Active-low level transfer request |
| cfg_cnt_wr | input | 1 | Load count and both base addresses (ignored while enabled) |
| cfg_cnt | input | CW | Number of transfer units |
| cfg_src | input | AW | Source start address (internal bus) |
| cfg_dst | input | AW | Destination start address (external bus) |
| cfg_en_wr | input | 1 | Write strobe for the channel enable |
| cfg_en | input | 1 | Enable value written by `cfg_en_wr` |
| wbuf_on | input | 1 | Buffer mode, captured when the channel is enabled |
| int_req | output | 1 | Internal bus read request |
| int_addr | output | AW | Internal read address |
| int_rdata | input | DW | Internal read data, valid with `int_ack` |
| int_ack | input | 1 | Internal bus acknowledge |
| ext_req | output | 1 | External bus write request |
| ext_addr | output | AW | External write address |
| ext_wdata | output | DW | External write data |
| ext_ack | input | 1 | External bus acknowledge |
| tend_n | output | 1 | Active-low end-of-transfer strobe |
| done | output | 1 | One-cycle completion pulse |
| ch_en | output | 1 | Channel enable state |

## Verification
The checker watches every cycle for the following:
- Bus requests are held until acknowledged.
- Reads and writes never overlap when the buffer mode is off.
- `done` lasts one cycle and coincides with a cleared enable.
- The end strobe appears only beside an external write when unbuffered, and only in an idle-bus cycle when buffered.
- Nothing is left pending while a read runs.

The directed scenarios show what needs a history of stimulus: request pulses ignored while a unit is busy, address and data sequences, the count running out, a zero count, overlap when the external side is slow, and the strobe being dropped or kept depending on how fast the external slave answers.

// File: rtl/dwb_pkg.sv
package dwb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_WRITE,
      ST_WAITW,
      ST_DEAD
   } seq_st_e;
endpackage

// File: rtl/dwb_req_gate.sv
module dwb_req_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic req_n,
   input  logic open,
   input  logic take,
   output logic pend
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pend <= 1'b0;
      else if (take)             pend <= 1'b0;
      else if (open && !req_n)   pend <= 1'b1;
   end
endmodule

// File: rtl/dwb_tc.sv
module dwb_tc #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [CW-1:0] ld_val,
   input  logic          en_wr,
   input  logic          en_din,
   input  logic          dec,
   input  logic          fin,
   output logic          en,
   output logic          last,
   output logic          done
);
   localparam logic [CW-1:0] ONE = CW'(1);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (ld && !en)    cnt_q <= ld_val;
      else if (dec)          cnt_q <= cnt_q - ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en <= 1'b0;
      else if (fin)    en <= 1'b0;
      else if (en_wr)  en <= en_din && (cnt_q != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done <= 1'b0;
      else        done <= fin;
   end

   assign last = (cnt_q == ONE);
endmodule

// File: rtl/dwb_wbuf.sv
module dwb_wbuf #(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] ld_addr,
   input  logic [DW-1:0] ld_data,
   input  logic          ld_last,
   input  logic          ack,
   output logic          valid,
   output logic [AW-1:0] addr,
   output logic [DW-1:0] data,
   output logic          last
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         addr  <= '0;
         data  <= '0;
         last  <= 1'b0;
      end else if (load) begin
         valid <= 1'b1;
         addr  <= ld_addr;
         data  <= ld_data;
         last  <= ld_last;
      end else if (ack) begin
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/dma_wbuf_seq.sv
module dma_wbuf_seq
   import dwb_pkg::*;
#(
   parameter int AW           = 16,
   parameter int DW           = 16,
   parameter int CW           = 16,
   parameter bit WBUF_PRESENT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_n,
   input  logic          cfg_cnt_wr,
   input  logic [CW-1:0] cfg_cnt,
   input  logic [AW-1:0] cfg_src,
   input  logic [AW-1:0] cfg_dst,
   input  logic          cfg_en_wr,
   input  logic          cfg_en,
   input  logic          wbuf_on,
   output logic          int_req,
   output logic [AW-1:0] int_addr,
   input  logic [DW-1:0] int_rdata,
   input  logic          int_ack,
   output logic          ext_req,
   output logic [AW-1:0] ext_addr,
   output logic [DW-1:0] ext_wdata,
   input  logic          ext_ack,
   output logic          tend_n,
   output logic          done,
   output logic          ch_en
);
   localparam logic [AW-1:0] ADDR_STEP = AW'(1);

   if (CW < 2 || AW < 1 || DW < 1) begin : g_bad_cfg
      $error("dma_wbuf_seq: CW must be at least 2, AW and DW at least 1");
   end

   seq_st_e       st_q, st_d;
   logic [AW-1:0] src_q, dst_q;
   logic [DW-1:0] rd_q;
   logic          mode_q;
   logic          pend, open, take, hand, fin, last;
   logic          wb_valid, wb_last, wb_load, wb_ack;
   logic [AW-1:0] wb_addr;
   logic [DW-1:0] wb_data;

   // buffer mode is fixed for the whole run once the channel is enabled
   if (WBUF_PRESENT) begin : g_wbuf_mode
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         mode_q <= 1'b0;
         else if (cfg_en_wr && !ch_en)       mode_q <= wbuf_on;
      end
   end else begin : g_no_wbuf_mode
      logic unused_wbuf_on;
      assign unused_wbuf_on = wbuf_on;
      assign mode_q = 1'b0;
   end

   assign open = ch_en && (st_q == ST_IDLE) && !pend;
   assign take = ch_en && (st_q == ST_IDLE) && pend && (mode_q || !wb_valid);
   assign hand = (st_q == ST_WRITE) && !wb_valid;
   assign wb_load = hand && !ext_ack;
   assign wb_ack  = wb_valid && ext_ack;

   assign fin = (st_q == ST_DEAD)
              || (hand && !mode_q && ext_ack && last)
              || ((st_q == ST_WAITW) && wb_ack && wb_last);

   dwb_req_gate u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .req_n (req_n),
      .open  (open),
      .take  (take),
      .pend  (pend)
   );

   dwb_tc #(.CW(CW)) u_tc (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (cfg_cnt_wr),
      .ld_val (cfg_cnt),
      .en_wr  (cfg_en_wr),
      .en_din (cfg_en),
      .dec    (hand),
      .fin    (fin),
      .en     (ch_en),
      .last   (last),
      .done   (done)
   );

   dwb_wbuf #(.AW(AW), .DW(DW)) u_wbuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (wb_load),
      .ld_addr (dst_q),
      .ld_data (rd_q),
      .ld_last (last),
      .ack     (wb_ack),
      .valid   (wb_valid),
      .addr    (wb_addr),
      .data    (wb_data),
      .last    (wb_last)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:  if (take) st_d = ST_READ;
         ST_READ:  if (int_ack) st_d = ST_WRITE;
         ST_WRITE: if (hand) begin
                      if (mode_q)       st_d = last ? ST_DEAD : ST_IDLE;
                      else if (ext_ack) st_d = ST_IDLE;
                      else              st_d = ST_WAITW;
                   end
         ST_WAITW: if (wb_ack) st_d = ST_IDLE;
         ST_DEAD:  st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         src_q <= '0;
         dst_q <= '0;
         rd_q  <= '0;
      end else begin
         st_q <= st_d;
         if (cfg_cnt_wr && !ch_en) begin
            src_q <= cfg_src;
            dst_q <= cfg_dst;
         end else begin
            if ((st_q == ST_READ) && int_ack) begin
               rd_q  <= int_rdata;
               src_q <= src_q + ADDR_STEP;
            end
            if (hand) dst_q <= dst_q + ADDR_STEP;
         end
      end
   end

   assign int_req   = (st_q == ST_READ);
   assign int_addr  = src_q;
   assign ext_req   = wb_valid || (st_q == ST_WRITE);
   assign ext_addr  = wb_valid ? wb_addr : dst_q;
   assign ext_wdata = wb_valid ? wb_data : rd_q;

   always_comb begin
      if (mode_q) tend_n = !((st_q == ST_DEAD) && !wb_valid);
      else        tend_n = !((hand && last) || (wb_valid && wb_last));
   end
endmodule

// File: rtl/dma_wbuf_seq_chk.sv
module dma_wbuf_seq_chk #(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          int_req,
   input logic          int_ack,
   input logic [AW-1:0] int_addr,
   input logic          ext_req,
   input logic          ext_ack,
   input logic [AW-1:0] ext_addr,
   input logic [DW-1:0] ext_wdata,
   input logic          tend_n,
   input logic          done,
   input logic          ch_en,
   input logic          mode_q,
   input logic          pend
);
   // R6
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q && int_req) |-> !ext_req);

   // R8
   ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr) && $stable(ext_wdata)));

   // R12
   int_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int_req && !int_ack) |=> (int_req && $stable(int_addr)));

   // R4
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R4
   done_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !ch_en);

   // R10
   tend_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tend_n && !mode_q) |-> ext_req);

   // R11
   tend_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tend_n && mode_q) |-> (!ext_req && !int_req));

   // R2
   closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_req |-> !pend);
endmodule

bind dma_wbuf_seq dma_wbuf_seq_chk #(.AW(AW), .DW(DW)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .int_req   (int_req),
   .int_ack   (int_ack),
   .int_addr  (int_addr),
   .ext_req   (ext_req),
   .ext_ack   (ext_ack),
   .ext_addr  (ext_addr),
   .ext_wdata (ext_wdata),
   .tend_n    (tend_n),
   .done      (done),
   .ch_en     (ch_en),
   .mode_q    (mode_q),
   .pend      (pend)
);

// File: tb/dma_wbuf_seq_tb_top.sv
module dma_wbuf_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int DW = 16;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_n = 1'b1;
   logic          cfg_cnt_wr = 1'b0;
   logic [CW-1:0] cfg_cnt = '0;
   logic [AW-1:0] cfg_src = '0;
   logic [AW-1:0] cfg_dst = '0;
   logic          cfg_en_wr = 1'b0;
   logic          cfg_en = 1'b0;
   logic          wbuf_on = 1'b0;
   logic          int_req, int_ack, ext_req, ext_ack, tend_n, done, ch_en;
   logic [AW-1:0] int_addr, ext_addr;
   logic [DW-1:0] int_rdata, ext_wdata;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;
   int int_lat = 0, ext_lat = 0;
   logic [3:0] icnt = '0, ecnt = '0;

   int cyc = 0, n_rd = 0, n_wr = 0, n_ovl = 0, n_tend = 0, n_tend_ext = 0;
   int n_tend_int = 0, n_done = 0, t_tend = 0, t_done = 0;
   logic [AW-1:0] wa [64];
   logic [DW-1:0] wd [64];

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_wbuf_seq #(.AW(AW), .DW(DW), .CW(CW), .WBUF_PRESENT(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_n(req_n),
      .cfg_cnt_wr(cfg_cnt_wr), .cfg_cnt(cfg_cnt), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
      .cfg_en_wr(cfg_en_wr), .cfg_en(cfg_en), .wbuf_on(wbuf_on),
      .int_req(int_req), .int_addr(int_addr), .int_rdata(int_rdata), .int_ack(int_ack),
      .ext_req(ext_req), .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_ack(ext_ack),
      .tend_n(tend_n), .done(done), .ch_en(ch_en)
   );

   // bus slaves with programmable wait states
   assign int_ack   = int_req && (icnt == int_lat[3:0]);
   assign ext_ack   = ext_req && (ecnt == ext_lat[3:0]);
   assign int_rdata = int_addr ^ 16'hA5A5;

   always @(posedge clk) begin
      if (!int_req || int_ack) icnt <= '0; else icnt <= icnt + 4'd1;
      if (!ext_req || ext_ack) ecnt <= '0; else ecnt <= ecnt + 4'd1;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         cyc = cyc + 1;
         if (int_req && int_ack) n_rd = n_rd + 1;
         if (ext_req && ext_ack) begin
            wa[n_wr % 64] = ext_addr;
            wd[n_wr % 64] = ext_wdata;
            n_wr = n_wr + 1;
         end
         if (int_req && ext_req) n_ovl = n_ovl + 1;
         if (!tend_n) begin
            n_tend = n_tend + 1;
            t_tend = cyc;
            if (ext_req) n_tend_ext = n_tend_ext + 1;
            if (int_req) n_tend_int = n_tend_int + 1;
         end
         if (done) begin
            n_done = n_done + 1;
            t_done = cyc;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      end
   endtask

   task automatic program_ch(input int cnt, input int src, input int dst, input bit bufm);
      @(negedge clk);
      cfg_cnt_wr = 1'b1; cfg_cnt = CW'(cnt); cfg_src = AW'(src); cfg_dst = AW'(dst);
      @(negedge clk);
      cfg_cnt_wr = 1'b0; cfg_en_wr = 1'b1; cfg_en = 1'b1; wbuf_on = bufm;
      @(negedge clk);
      cfg_en_wr = 1'b0;
   endtask

   task automatic wait_done(input string tag);
      int base = n_done;
      for (int i = 0; i < 600 && n_done == base; i++) @(negedge clk);
      chk(n_done == base + 1, tag, n_done - base, 1);
   endtask

   task automatic chk_writes(input int first, input int n, input int src, input int dst);
      for (int k = 0; k < n; k++) begin
         chk(wa[(first + k) % 64] == AW'(dst + k), "R3 write address",
             int'(wa[(first + k) % 64]), dst + k);
         chk(wd[(first + k) % 64] == (DW'(src + k) ^ 16'hA5A5), "R3 write data",
             int'(wd[(first + k) % 64]), int'(DW'(src + k) ^ 16'hA5A5));
      end
   endtask

   task automatic t_reset();
      chk(ch_en == 1'b0, "reset ch_en", ch_en, 0);
      chk(tend_n == 1'b1, "reset tend_n", tend_n, 1);
      chk(done == 1'b0 && int_req == 1'b0 && ext_req == 1'b0, "reset requests/done",
          int'({done, int_req, ext_req}), 0);
   endtask

   task automatic t_unbuffered();
      int w0 = n_wr, r0 = n_rd, o0 = n_ovl, te0 = n_tend, tx0 = n_tend_ext, d0 = n_done;
      int_lat = 1; ext_lat = 2;
      program_ch(3, 16'h0100, 16'h8000, 1'b0);
      req_n = 1'b0;
      wait_done("R4 done after unbuffered run");
      chk(n_wr - w0 == 3, "R3 unbuffered write count", n_wr - w0, 3);
      chk(n_rd - r0 == 3, "R12 read count", n_rd - r0, 3);
      chk_writes(w0, 3, 16'h0100, 16'h8000);
      chk(n_ovl == o0, "R6 no overlap unbuffered", n_ovl - o0, 0);
      chk(n_tend - te0 == 3, "R10 tend_n low cycles", n_tend - te0, 3);
      chk(n_tend_ext - tx0 == 3, "R10 tend_n with external write", n_tend_ext - tx0, 3);
      chk(ch_en == 1'b0, "R4 enable cleared", ch_en, 0);
      repeat (12) @(negedge clk);
      chk(n_rd - r0 == 3, "R4 no reads after count exhausted", n_rd - r0, 3);
      chk(n_done - d0 == 1, "R4 single done pulse", n_done - d0, 1);
      req_n = 1'b1;
   endtask

   task automatic t_buffered_slow();
      int w0 = n_wr, o0 = n_ovl, te0 = n_tend;
      int_lat = 0; ext_lat = 3;
      program_ch(4, 16'h0200, 16'h9000, 1'b1);
      req_n = 1'b0;
      wait_done("R4 done after buffered run");
      req_n = 1'b1;
      repeat (10) @(negedge clk);
      chk(n_ovl - o0 > 0, "R7 write overlaps next read", n_ovl - o0, 1);
      chk(n_wr - w0 == 4, "R8 buffered write count", n_wr - w0, 4);
      chk_writes(w0, 4, 16'h0200, 16'h9000);
      chk(n_tend == te0, "R11 tend_n suppressed by posted write", n_tend - te0, 0);
   endtask

   task automatic t_buffered_fast();
      int te0 = n_tend, tx0 = n_tend_ext, ti0 = n_tend_int, w0 = n_wr;
      int_lat = 0; ext_lat = 0;
      program_ch(2, 16'h0300, 16'hA000, 1'b1);
      req_n = 1'b0;
      wait_done("R9 done after fast buffered run");
      req_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(n_wr - w0 == 2, "R3 fast buffered write count", n_wr - w0, 2);
      chk(n_tend - te0 == 1, "R11 tend_n in free dead cycle", n_tend - te0, 1);
      chk(n_tend_ext == tx0 && n_tend_int == ti0, "R9 dead cycle has no bus request",
          (n_tend_ext - tx0) + (n_tend_int - ti0), 0);
      chk(t_done == t_tend + 1, "R9 done follows dead cycle", t_done - t_tend, 1);
   endtask

   task automatic t_zero_count();
      int r0 = n_rd;
      program_ch(0, 16'h0400, 16'hB000, 1'b0);
      req_n = 1'b0;
      repeat (10) @(negedge clk);
      req_n = 1'b1;
      chk(ch_en == 1'b0, "R5 enable ignored at zero count", ch_en, 0);
      chk(n_rd == r0, "R5 no transfer at zero count", n_rd - r0, 0);
   endtask

   task automatic t_gate();
      int r0 = n_rd, w0 = n_wr;
      int_lat = 4; ext_lat = 0;
      program_ch(3, 16'h0500, 16'hC000, 1'b0);
      req_n = 1'b0;
      @(negedge clk);
      req_n = 1'b1;
      chk(int_req == 1'b0, "R1 no read in latch cycle", int_req, 0);
      @(negedge clk);
      chk(int_req == 1'b1, "R1 read starts after latch", int_req, 1);
      req_n = 1'b0;
      @(negedge clk);
      req_n = 1'b1;
      repeat (20) @(negedge clk);
      chk(n_rd - r0 == 1, "R2 pulse during unit ignored", n_rd - r0, 1);
      chk(n_wr - w0 == 1, "R2 one write per accepted request", n_wr - w0, 1);
      req_n = 1'b0;
      @(negedge clk);
      req_n = 1'b1;
      repeat (20) @(negedge clk);
      chk(n_rd - r0 == 2, "R1 second pulse accepted when idle", n_rd - r0, 2);
      req_n = 1'b0;
      wait_done("R4 done after gated run");
      req_n = 1'b1;
      chk_writes(w0, 3, 16'h0500, 16'hC000);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_unbuffered();
      t_buffered_slow();
      t_buffered_fast();
      t_zero_count();
      t_gate();
      repeat (5) @(negedge clk);
      summary();
      $finish;
   end
endmodule